// File: doc/BRIEF.md
# Activity-Gated Studio-Range YCbCr to RGB Converter

This block turns one studio-range YCbCr pixel per clock into an 8-bit RGB triple using fixed-point standard-definition conversion equations. Each colour component arrives on a 10-bit bus. Only the eight most significant bits of each component enter the arithmetic. Every result is rounded and then clamped to the 0 to 255 range.

A change detector sits in front of the arithmetic. It keeps a copy of the last Y, Cb and Cr samples and XORs that copy with the current samples. The output registers load only on cycles where at least one bit differs. On a run of identical pixels the registers hold their value, so the datapath flops see no activity for the length of the run. The first pixel after reset release is always converted. A running count of converted pixels is brought out so that a surrounding system or a bench can measure how much activity the gate suppressed.

Top module: `ycc_gated_rgb_top`

## Requirements
- R1: While `rst_n` is low at a rising edge, the three colour outputs and `conv_count` are zero after that edge.
- R2: The first rising edge with `rst_n` high converts the current pixel and increments `conv_count`, even when the pixel equals the cleared history (all zero).
- R3: The red output is the clamp of floor((1192·(Y−16) + 1634·(Cr−128) + 512) / 1024), where Y, Cb and Cr are bits [9:2] of the inputs.
- R4: The green output is the clamp of floor((1192·(Y−16) − 833·(Cr−128) − 400·(Cb−128) + 512) / 1024).
- R5: The blue output is the clamp of floor((1192·(Y−16) + 2066·(Cb−128) + 512) / 1024).
- R6: Bits [1:0] of the inputs do not affect the colour outputs. Such a change still counts as a changed pixel: the outputs reload with the same values and `conv_count` increments.
- R7: Results below 0 give 0, and results above 255 give 255.
- R8: When all 30 input bits equal the previous cycle's inputs (and it is not the first cycle after reset), the colour outputs and `conv_count` keep their values.
- R9: A converted pixel appears on the outputs one rising edge after it is presented. `conv_count` rises by exactly one at that same edge and never changes otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| y_in | input | 10 | Luma sample |
| cb_in | input | 10 | Blue-difference chroma sample |
| cr_in | input | 10 | Red-difference chroma sample |
| r_out | output | 8 | Registered red result |
| g_out | output | 8 | Registered green result |
| b_out | output | 8 | Registered blue result |
| conv_count | output | 16 | Number of converted pixels since reset (wraps) |

## Verification
The converter is tried with several kinds of input:
- **Neutral greys at the nominal limits** pin the luma gain and the rounding.
- **Saturated colours** push each channel through both clamp limits, which separates wrong coefficient signs from wrong clamping.
- **Runs of repeated pixels, mixed into a pseudo-random stream,** show whether the gate really freezes the outputs and the counter.
- **Pixels differing only in their two low bits** separate the comparison width (full bus) from the arithmetic width (upper byte).
- **An all-zero pixel held through reset release** shows whether the forced first conversion happens.

// File: rtl/ycc_pkg.sv
// Package: shared constants for the activity-gated colour converter.
// Assumes 8-bit studio-range arithmetic; coefficients are scaled by 2^FRAC.
package ycc_pkg;
    localparam int NUM_COMP = 3;   // number of colour components per pixel
    localparam int FRAC     = 10;  // fractional bits of the coefficients
    localparam int K_LUMA   = 1192;

    // channel index order: 0 = red, 1 = green, 2 = blue
    typedef enum int {CH_RED = 0, CH_GREEN = 1, CH_BLUE = 2} chan_e;

    // weight applied to (Cr - mid) for a channel
    function automatic int cr_weight(input int ch);
        case (ch)
            CH_RED:   return 1634;
            CH_GREEN: return -833;
            default:  return 0;
        endcase
    endfunction

    // weight applied to (Cb - mid) for a channel
    function automatic int cb_weight(input int ch);
        case (ch)
            CH_GREEN: return -400;
            CH_BLUE:  return 2066;
            default:  return 0;
        endcase
    endfunction
endpackage

// File: rtl/ycc_change_detect.sv
// Module: ycc_change_detect
// Keeps the previous sample of each component and flags cycles where any
// bit differs. Also forces one enable on the first cycle after reset.
// Assumes a synchronous active-low reset; history updates every cycle.
module ycc_change_detect #(
    parameter int IN_W = 10,
    parameter int NC   = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NC-1:0][IN_W-1:0] comp_in,
    output logic                    conv_en
);
    logic [NC-1:0][IN_W-1:0] hist_q;
    logic [NC-1:0]           diff;
    logic                    first_q;

    // per-component XOR comparison against the stored copy
    for (genvar c = 0; c < NC; c++) begin : g_cmp
        assign diff[c] = |(comp_in[c] ^ hist_q[c]);
    end

    // history registers: load the current sample on every cycle
    always_ff @(posedge clk) begin
        if (!rst_n) hist_q <= '0;
        else        hist_q <= comp_in;
    end

    // first-cycle flag: set in reset, cleared after one active cycle
    always_ff @(posedge clk) begin
        if (!rst_n) first_q <= 1'b1;
        else        first_q <= 1'b0;
    end

    // enable when any component changed or right after reset release
    always_comb conv_en = first_q | (|diff);
endmodule

// File: rtl/ycc_matrix.sv
// Module: ycc_matrix
// Combinational fixed-point colour matrix: offset, multiply-accumulate,
// round half-up, arithmetic shift and clamp, one generated lane per channel.
// Assumes PIX_W >= 8 so the studio offsets scale by shifting.
module ycc_matrix #(
    parameter int PIX_W = 8
) (
    input  logic [PIX_W-1:0] y_px,
    input  logic [PIX_W-1:0] cb_px,
    input  logic [PIX_W-1:0] cr_px,
    output logic [2:0][PIX_W-1:0] rgb_px
);
    import ycc_pkg::*;

    localparam int ACC_W    = PIX_W + FRAC + 6;
    localparam int LUMA_OFS = 16 << (PIX_W - 8);
    localparam int MID      = 1 << (PIX_W - 1);
    localparam int PIX_MAX  = (1 << PIX_W) - 1;
    localparam logic signed [ACC_W-1:0] HALF   = ACC_W'(1) <<< (FRAC - 1);
    localparam logic signed [ACC_W-1:0] K_Y    = ACC_W'(K_LUMA);
    localparam logic signed [ACC_W-1:0] TOPVAL = ACC_W'(PIX_MAX);

    logic signed [ACC_W-1:0] ys, cs, ds;

    // remove studio offsets, widening to the accumulator width
    always_comb begin
        ys = $signed({{(ACC_W-PIX_W){1'b0}}, y_px})  - ACC_W'(LUMA_OFS);
        cs = $signed({{(ACC_W-PIX_W){1'b0}}, cr_px}) - ACC_W'(MID);
        ds = $signed({{(ACC_W-PIX_W){1'b0}}, cb_px}) - ACC_W'(MID);
    end

    for (genvar ch = 0; ch < 3; ch++) begin : g_lane
        localparam logic signed [ACC_W-1:0] KC = ACC_W'(cr_weight(ch));
        localparam logic signed [ACC_W-1:0] KD = ACC_W'(cb_weight(ch));
        logic signed [ACC_W-1:0] acc, shifted;

        // multiply-accumulate with rounding, then clamp to pixel range
        always_comb begin
            acc     = K_Y * ys + KC * cs + KD * ds + HALF;
            shifted = acc >>> FRAC;
            if (shifted < 0)           rgb_px[ch] = '0;
            else if (shifted > TOPVAL) rgb_px[ch] = PIX_W'(PIX_MAX);
            else                       rgb_px[ch] = shifted[PIX_W-1:0];
        end
    end
endmodule

// File: rtl/ycc_out_stage.sv
// Module: ycc_out_stage
// Output registers for the three channels, loaded only when enabled.
// Assumes a synchronous active-low reset that clears them.
module ycc_out_stage #(
    parameter int PIX_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  load_en,
    input  logic [2:0][PIX_W-1:0] rgb_d,
    output logic [2:0][PIX_W-1:0] rgb_q
);
    for (genvar ch = 0; ch < 3; ch++) begin : g_reg
        // channel register with synchronous enable
        always_ff @(posedge clk) begin
            if (!rst_n)       rgb_q[ch] <= '0;
            else if (load_en) rgb_q[ch] <= rgb_d[ch];
        end
    end
endmodule

// File: rtl/ycc_activity_counter.sv
// Module: ycc_activity_counter
// Counts enabled conversion cycles; wraps at its width.
module ycc_activity_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    output logic [CNT_W-1:0] count
);
    // increment once per converted pixel
    always_ff @(posedge clk) begin
        if (!rst_n)    count <= '0;
        else if (tick) count <= count + CNT_W'(1);
    end
endmodule

// File: rtl/ycc_gated_rgb_top.sv
// Module: ycc_gated_rgb_top
// Activity-gated YCbCr to RGB converter. The change detector enables the
// output registers and the activity counter; the matrix is combinational.
// Assumes IN_W >= PIX_W; the upper PIX_W bits of each input are converted.
module ycc_gated_rgb_top #(
    parameter int IN_W  = 10,
    parameter int PIX_W = 8,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IN_W-1:0]  y_in,
    input  logic [IN_W-1:0]  cb_in,
    input  logic [IN_W-1:0]  cr_in,
    output logic [PIX_W-1:0] r_out,
    output logic [PIX_W-1:0] g_out,
    output logic [PIX_W-1:0] b_out,
    output logic [CNT_W-1:0] conv_count
);
    import ycc_pkg::*;

    logic [NUM_COMP-1:0][IN_W-1:0] comp_bus;
    logic [2:0][PIX_W-1:0]         rgb_comb, rgb_reg;
    logic                          conv_en;

    // gather the components for the change detector
    always_comb comp_bus = {cr_in, cb_in, y_in};

    ycc_change_detect #(.IN_W(IN_W), .NC(NUM_COMP)) u_detect (
        .clk     (clk),
        .rst_n   (rst_n),
        .comp_in (comp_bus),
        .conv_en (conv_en)
    );

    ycc_matrix #(.PIX_W(PIX_W)) u_matrix (
        .y_px   (y_in[IN_W-1 -: PIX_W]),
        .cb_px  (cb_in[IN_W-1 -: PIX_W]),
        .cr_px  (cr_in[IN_W-1 -: PIX_W]),
        .rgb_px (rgb_comb)
    );

    ycc_out_stage #(.PIX_W(PIX_W)) u_out (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_en (conv_en),
        .rgb_d   (rgb_comb),
        .rgb_q   (rgb_reg)
    );

    ycc_activity_counter #(.CNT_W(CNT_W)) u_count (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (conv_en),
        .count (conv_count)
    );

    // split the registered channels onto the ports
    always_comb begin
        r_out = rgb_reg[CH_RED];
        g_out = rgb_reg[CH_GREEN];
        b_out = rgb_reg[CH_BLUE];
    end
endmodule

// File: rtl/ycc_gated_rgb_chk.sv
// Checker for ycc_gated_rgb_top, attached by bind.
module ycc_gated_rgb_chk #(
    parameter int IN_W  = 10,
    parameter int PIX_W = 8,
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [IN_W-1:0]  y_in,
    input logic [IN_W-1:0]  cb_in,
    input logic [IN_W-1:0]  cr_in,
    input logic [PIX_W-1:0] r_out,
    input logic [PIX_W-1:0] g_out,
    input logic [PIX_W-1:0] b_out,
    input logic [CNT_W-1:0] conv_count
);
    logic reset_seen;

    // note that a reset edge has occurred
    always_ff @(posedge clk) begin
        if (!rst_n) reset_seen <= 1'b1;
    end

    // R1
    always @(negedge clk) begin
        if (!rst_n && reset_seen === 1'b1)
            reset_clear_chk: assert (r_out == '0 && g_out == '0 && b_out == '0 && conv_count == '0)
                else $error("outputs not cleared in reset");
    end

    // R2
    first_convert_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |=> conv_count == CNT_W'(1));

    // R8
    repeat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && y_in == $past(y_in) && cb_in == $past(cb_in) && cr_in == $past(cr_in))
        |=> ($stable(r_out) && $stable(g_out) && $stable(b_out) && $stable(conv_count)));

    // R9
    change_counts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && (y_in != $past(y_in) || cb_in != $past(cb_in) || cr_in != $past(cr_in)))
        |=> conv_count == $past(conv_count) + CNT_W'(1));

    // R9
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (conv_count == $past(conv_count) || conv_count == $past(conv_count) + CNT_W'(1)));
endmodule

bind ycc_gated_rgb_top ycc_gated_rgb_chk #(.IN_W(IN_W), .PIX_W(PIX_W), .CNT_W(CNT_W)) u_chk (.*);

// File: tb/ycc_gated_rgb_tb.sv
`timescale 1ns/100ps
module ycc_gated_rgb_top_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [9:0] y_in = '0, cb_in = '0, cr_in = '0;
    logic [7:0] r_out, g_out, b_out;
    logic [15:0] conv_count;

    int checks = 0;
    int errors = 0;

    typedef struct {
        logic [7:0]  r, g, b;
        logic [15:0] cnt;
        string       tag;
    } exp_t;

    exp_t       sb_q[$];
    exp_t       item;
    logic [7:0] er = '0, eg = '0, eb = '0;
    logic [15:0] ecnt = '0;
    logic [29:0] prev_in = '0;
    bit         first = 1'b1;

    always #2.5 clk = ~clk;

    ycc_gated_rgb_top dut_i (.*);

    // requirement model: R3/R4/R5 equations with R7 clamp
    function automatic logic [7:0] model(input int ch, input int y, input int cb, input int cr);
        int v, q, kc, kd;
        kc = (ch == 0) ? 1634 : (ch == 1) ? -833 : 0;
        kd = (ch == 1) ? -400 : (ch == 2) ? 2066 : 0;
        v = 1192 * (y - 16) + kc * (cr - 128) + kd * (cb - 128) + 512;
        q = (v >= 0) ? v / 1024 : -((-v + 1023) / 1024);
        if (q < 0) q = 0;
        if (q > 255) q = 255;
        return 8'(q);
    endfunction

    task automatic check(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // driver: called at a negedge, presents a pixel, pushes the expectation
    task automatic drive(input logic [9:0] y, input logic [9:0] cb, input logic [9:0] cr, input string tag);
        logic [29:0] cur;
        cur = {cr, cb, y};
        y_in = y; cb_in = cb; cr_in = cr;
        if (first || cur != prev_in) begin
            er = model(0, int'(y[9:2]), int'(cb[9:2]), int'(cr[9:2]));
            eg = model(1, int'(y[9:2]), int'(cb[9:2]), int'(cr[9:2]));
            eb = model(2, int'(y[9:2]), int'(cb[9:2]), int'(cr[9:2]));
            ecnt = ecnt + 16'd1;
        end
        first = 1'b0;
        prev_in = cur;
        @(posedge clk);
        #1;
        sb_q.push_back('{er, eg, eb, ecnt, tag});
        @(negedge clk);
    endtask

    // pixel helper on 8-bit values
    task automatic px8(input int y, input int cb, input int cr, input string tag);
        drive(10'(y << 2), 10'(cb << 2), 10'(cr << 2), tag);
    endtask

    // monitor: compares outputs one edge after each pixel (R9 latency)
    always @(negedge clk) begin
        if (sb_q.size() > 0) begin
            item = sb_q.pop_front();
            check(item.tag, "red",   int'(r_out), int'(item.r));
            check(item.tag, "green", int'(g_out), int'(item.g));
            check(item.tag, "blue",  int'(b_out), int'(item.b));
            check({item.tag, "/R9"}, "count", int'(conv_count), int'(item.cnt));
        end
    end

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] lfsr;
        logic [9:0]  ly, lb, lr;
        lfsr = 16'hACE1;
        ly = '0; lb = '0; lr = '0;
        // R1: outputs cleared during reset
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1", "red",   int'(r_out), 0);
        check("R1", "green", int'(g_out), 0);
        check("R1", "blue",  int'(b_out), 0);
        check("R1", "count", int'(conv_count), 0);
        // R2: all-zero pixel across reset release is still converted
        rst_n = 1'b1;
        drive(10'd0, 10'd0, 10'd0, "R2");
        // R8: the same zero pixel again is held
        drive(10'd0, 10'd0, 10'd0, "R8");
        // R3 R4 R5: greys and colours
        px8(16, 128, 128, "R3");
        px8(235, 128, 128, "R4");
        px8(126, 128, 128, "R5");
        px8(81, 90, 240, "R3");
        px8(145, 54, 34, "R4");
        px8(41, 240, 110, "R5");
        px8(170, 166, 16, "R4");
        // R7: clamp both ends
        px8(235, 240, 240, "R7");
        px8(16, 16, 16, "R7");
        px8(16, 240, 16, "R7");
        // R8: a run of repeats holds outputs and count
        for (int i = 0; i < 6; i++) px8(100, 150, 60, "R8");
        // R6: only the low bits change
        drive(10'(200 << 2) | 10'd1, 10'(70 << 2), 10'(180 << 2), "R6");
        drive(10'(200 << 2) | 10'd3, 10'(70 << 2) | 10'd2, 10'(180 << 2), "R6");
        drive(10'(200 << 2) | 10'd3, 10'(70 << 2) | 10'd2, 10'(180 << 2) | 10'd1, "R6");
        // mixed stream with runs of repeats
        for (int i = 0; i < 300; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            if (lfsr[1:0] != 2'b00) begin
                ly = 10'(lfsr * 7);
                lb = 10'(lfsr * 13 + 5);
                lr = 10'({lfsr[7:0], lfsr[15:14]});
            end
            drive(ly, lb, lr, (lfsr[1:0] == 2'b00) ? "R8" : "R3");
        end
        repeat (3) @(negedge clk);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule